// File: doc/BRIEF.md
# Loss-Free Front-End Reset Scheduler

This block decides when a front-end reset may be sent without losing any event. It keeps its own bunch position, which wraps at a programmable orbit length. It also watches a status line that says the level-0 derandomizer has drained. A reset is asked for either by a one-cycle request strobe or by an optional interval timer. When a request arrives, the block first drops the trigger-accept enable and keeps it low for a fixed inhibit window. It then waits until two things are true in the same cycle: the bunch position lies inside the programmed bunch gap, and the derandomizer is empty. Only then does it drive the reset pulse.

After the pulse, the accept enable stays low through a reinitialisation window and then through a recovery window. Only after both does the block return to idle. If the derandomizer does not drain within a programmable number of cycles, the block gives up without resetting and sets a sticky flag. A saturating counter records how many reset pulses have been issued.

Top module: `fe_reset_sched`

## Requirements
- R1: `bx_pos` is 0 after reset and advances by one each cycle. It returns to 0 in the cycle after it has held `cfg_orbit_len`-1.
- R2: A request is a high `req_wr` or an interval tick, sampled while idle. It drops `trig_enable` and raises `busy` from the next cycle. Both then stay changed for INH_CYC cycles before the block starts waiting for the gap.
- R3: `fe_reset` rises only in the cycle after one in which the block was waiting, `bx_pos` lay in the inclusive range `cfg_gap_start`..`cfg_gap_end`, and `derand_empty` was high. It then stays high for exactly PULSE_CYC cycles.
- R4: While `derand_empty` is low, no reset pulse is issued and `reset_count` does not change.
- R5: `trig_enable` is low in every cycle from the inhibit window through the pulse, then for REINIT_CYC more cycles and RECOVER_CYC more cycles. After that it returns high.
- R6: With a non-zero `cfg_period` of P, an interval tick occurs every P cycles, and a tick counts as a request only while idle. With `cfg_period` = 0, no tick ever occurs.
- R7: Once waiting starts, the block allows `cfg_timeout`+1 wait cycles. If none of them has gap and empty together, it returns to idle without a pulse and sets `timeout_flag`. The flag stays set until `rst_n`.
- R8: In the last allowed wait cycle, if gap and empty also hold, the reset pulse wins and `timeout_flag` is not set.
- R9: `reset_count` increases by one for each pulse issued and stops at its all-ones value.
- R10: Requests that arrive while `busy` is high are dropped; they are neither queued nor counted.
- R11: During and right after reset, the outputs are: `trig_enable`=1, `fe_reset`=0, `busy`=0, `timeout_flag`=0, `reset_count`=0 and `bx_pos`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_orbit_len | input | BX_W | Bunch positions per orbit |
| cfg_gap_start | input | BX_W | First bunch position of the gap |
| cfg_gap_end | input | BX_W | Last bunch position of the gap |
| cfg_period | input | PER_W | Interval between automatic requests; 0 disables them |
| cfg_timeout | input | TO_W | Wait cycles allowed minus one |
| req_wr | input | 1 | On-demand reset request strobe |
| derand_empty | input | 1 | Derandomizer empty status |
| trig_enable | output | 1 | Trigger accepts allowed |
| fe_reset | output | 1 | Front-end reset pulse |
| busy | output | 1 | Reset sequence in progress |
| timeout_flag | output | 1 | Sticky: a sequence gave up waiting |
| reset_count | output | CNT_W | Saturating count of issued pulses |
| bx_pos | output | BX_W | Current bunch position |

## Verification
Two functions can fall in the same cycle: the final wait cycle that ends in a timeout, and the gap-and-empty condition that launches the pulse. To force both into one cycle, the bench sets the timeout to zero, opens the gap over the whole orbit and holds the derandomizer empty, so the single wait cycle carries both. The bench expects a pulse, a counter step and a clear timeout flag. A second run with the derandomizer full must give the opposite result. A second overlap also occurs: an interval tick or a request strobe can arrive while a sequence is busy. Here the bench's reference model expects the event to be dropped.

// File: rtl/fers_pkg.sv
package fers_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_INHIBIT = 3'd1,
    ST_WAIT    = 3'd2,
    ST_PULSE   = 3'd3,
    ST_REINIT  = 3'd4,
    ST_RECOVER = 3'd5
  } fers_state_e;
endpackage

// File: rtl/fers_bx_counter.sv
module fers_bx_counter #(
  parameter int BX_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BX_W-1:0] orbit_len,
  input  logic [BX_W-1:0] gap_start,
  input  logic [BX_W-1:0] gap_end,
  output logic [BX_W-1:0] bx,
  output logic            in_gap
);
  logic [BX_W:0] bx_inc;

  assign bx_inc = {1'b0, bx} + (BX_W+1)'(1);
  assign in_gap = (bx >= gap_start) && (bx <= gap_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx <= '0;
    end else if (bx_inc >= {1'b0, orbit_len}) begin
      bx <= '0;
    end else begin
      bx <= bx_inc[BX_W-1:0];
    end
  end
endmodule

// File: rtl/fers_period_timer.sv
module fers_period_timer #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] tmr;
  logic             enabled;

  assign enabled = (period != '0);
  assign tick    = enabled && (tmr == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (!enabled || tick) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/fers_fsm.sv
module fers_fsm
  import fers_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int CNT_W       = 16,
  parameter int INH_CYC     = 16,
  parameter int PULSE_CYC   = 4,
  parameter int REINIT_CYC  = 100,
  parameter int RECOVER_CYC = 160
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            in_gap,
  input  logic            derand_empty,
  input  logic [TO_W-1:0] timeout,
  output fers_state_e     state,
  output logic            tmo_flag,
  output logic [CNT_W-1:0] rst_cnt
);
  localparam int FIX_A   = (INH_CYC > PULSE_CYC) ? INH_CYC : PULSE_CYC;
  localparam int FIX_B   = (REINIT_CYC > RECOVER_CYC) ? REINIT_CYC : RECOVER_CYC;
  localparam int FIX_MAX = (FIX_A > FIX_B) ? FIX_A : FIX_B;
  localparam int FIX_W   = $clog2(FIX_MAX + 1);
  localparam int PH_W    = (TO_W > FIX_W) ? TO_W : FIX_W;

  fers_state_e      nxt;
  logic [PH_W-1:0]  ph;
  logic             ph_clr;
  logic             cnt_inc;
  logic             tmo_set;

  always_comb begin
    nxt     = state;
    ph_clr  = 1'b0;
    cnt_inc = 1'b0;
    tmo_set = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_req) begin
          nxt    = ST_INHIBIT;
          ph_clr = 1'b1;
        end
      end
      ST_INHIBIT: begin
        if (ph == PH_W'(INH_CYC - 1)) begin
          nxt    = ST_WAIT;
          ph_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (in_gap && derand_empty) begin
          nxt     = ST_PULSE;
          ph_clr  = 1'b1;
          cnt_inc = 1'b1;
        end else if (ph == PH_W'(timeout)) begin
          nxt     = ST_IDLE;
          ph_clr  = 1'b1;
          tmo_set = 1'b1;
        end
      end
      ST_PULSE: begin
        if (ph == PH_W'(PULSE_CYC - 1)) begin
          nxt    = ST_REINIT;
          ph_clr = 1'b1;
        end
      end
      ST_REINIT: begin
        if (ph == PH_W'(REINIT_CYC - 1)) begin
          nxt    = ST_RECOVER;
          ph_clr = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (ph == PH_W'(RECOVER_CYC - 1)) begin
          nxt    = ST_IDLE;
          ph_clr = 1'b1;
        end
      end
      default: begin
        nxt    = ST_IDLE;
        ph_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (ph_clr) begin
      ph <= '0;
    end else if (state != ST_IDLE) begin
      ph <= ph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt <= '0;
    end else if (cnt_inc && (rst_cnt != '1)) begin
      rst_cnt <= rst_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
    end else if (tmo_set) begin
      tmo_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/fe_reset_sched.sv
module fe_reset_sched
  import fers_pkg::*;
#(
  parameter int BX_W        = 12,
  parameter int PER_W       = 24,
  parameter int TO_W        = 16,
  parameter int CNT_W       = 16,
  parameter int INH_CYC     = 16,
  parameter int PULSE_CYC   = 4,
  parameter int REINIT_CYC  = 100,
  parameter int RECOVER_CYC = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BX_W-1:0]  cfg_orbit_len,
  input  logic [BX_W-1:0]  cfg_gap_start,
  input  logic [BX_W-1:0]  cfg_gap_end,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [TO_W-1:0]  cfg_timeout,
  input  logic             req_wr,
  input  logic             derand_empty,
  output logic             trig_enable,
  output logic             fe_reset,
  output logic             busy,
  output logic             timeout_flag,
  output logic [CNT_W-1:0] reset_count,
  output logic [BX_W-1:0]  bx_pos
);
  logic        in_gap;
  logic        tick;
  fers_state_e state;

  fers_bx_counter #(.BX_W(BX_W)) u_bx (
    .clk(clk), .rst_n(rst_n), .orbit_len(cfg_orbit_len),
    .gap_start(cfg_gap_start), .gap_end(cfg_gap_end),
    .bx(bx_pos), .in_gap(in_gap)
  );

  fers_period_timer #(.PER_W(PER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .period(cfg_period), .tick(tick)
  );

  fers_fsm #(
    .TO_W(TO_W), .CNT_W(CNT_W), .INH_CYC(INH_CYC), .PULSE_CYC(PULSE_CYC),
    .REINIT_CYC(REINIT_CYC), .RECOVER_CYC(RECOVER_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(req_wr || tick), .in_gap(in_gap),
    .derand_empty(derand_empty), .timeout(cfg_timeout), .state(state),
    .tmo_flag(timeout_flag), .rst_cnt(reset_count)
  );

  assign trig_enable = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign fe_reset    = (state == ST_PULSE);
endmodule

// File: rtl/fe_reset_sched_chk.sv
module fe_reset_sched_chk #(
  parameter int BX_W  = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BX_W-1:0]  cfg_orbit_len,
  input logic [BX_W-1:0]  cfg_gap_start,
  input logic [BX_W-1:0]  cfg_gap_end,
  input logic             derand_empty,
  input logic             trig_enable,
  input logic             fe_reset,
  input logic             timeout_flag,
  input logic [CNT_W-1:0] reset_count,
  input logic [BX_W-1:0]  bx_pos
);
  assert_bx_in_orbit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_orbit_len != '0) && $stable(cfg_orbit_len) && ($past(bx_pos) < cfg_orbit_len))
      |-> (bx_pos < cfg_orbit_len));

  assert_pulse_in_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_reset) |-> ($past(derand_empty) && ($past(bx_pos) >= $past(cfg_gap_start))
                         && ($past(bx_pos) <= $past(cfg_gap_end))));

  assert_pulse_after_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_reset) |-> !$past(trig_enable));

  assert_no_accept_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fe_reset |-> !trig_enable);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reset_count == $past(reset_count)) || (reset_count == $past(reset_count) + 1'b1)));

  assert_count_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_count == '1) |=> (reset_count == '1));
endmodule

bind fe_reset_sched fe_reset_sched_chk #(.BX_W(BX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_orbit_len(cfg_orbit_len),
  .cfg_gap_start(cfg_gap_start), .cfg_gap_end(cfg_gap_end),
  .derand_empty(derand_empty), .trig_enable(trig_enable), .fe_reset(fe_reset),
  .timeout_flag(timeout_flag), .reset_count(reset_count), .bx_pos(bx_pos)
);

// File: tb/tb_fe_reset_sched.sv
module tb_fe_reset_sched;
  localparam int CLK_PER = 10;
  localparam int BX_W = 8, PER_W = 12, TO_W = 10, CNT_W = 3;
  localparam int INH = 16, PUL = 4, REI = 100, REC = 160;

  logic clk, rst_n, req_wr, derand_empty;
  logic [BX_W-1:0]  cfg_orbit_len, cfg_gap_start, cfg_gap_end;
  logic [PER_W-1:0] cfg_period;
  logic [TO_W-1:0]  cfg_timeout;
  logic trig_enable, fe_reset, busy, timeout_flag;
  logic [CNT_W-1:0] reset_count;
  logic [BX_W-1:0]  bx_pos;

  fe_reset_sched #(.BX_W(BX_W), .PER_W(PER_W), .TO_W(TO_W), .CNT_W(CNT_W),
    .INH_CYC(INH), .PULSE_CYC(PUL), .REINIT_CYC(REI), .RECOVER_CYC(REC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_orbit_len(cfg_orbit_len),
    .cfg_gap_start(cfg_gap_start), .cfg_gap_end(cfg_gap_end),
    .cfg_period(cfg_period), .cfg_timeout(cfg_timeout), .req_wr(req_wr),
    .derand_empty(derand_empty), .trig_enable(trig_enable), .fe_reset(fe_reset),
    .busy(busy), .timeout_flag(timeout_flag), .reset_count(reset_count), .bx_pos(bx_pos));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0, seen_rst = 0;

  initial clk = 0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Reference model: phase names and remaining-cycle countdown
  // 0 idle, 1 inhibit, 2 wait, 3 pulse, 4 reinit, 5 recover
  int m_ph, m_left, m_bx, m_tmr, m_cnt;
  bit m_tmo;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_bx = 0; m_tmr = 0; m_cnt = 0; m_tmo = 0;
    end else begin
      bit tick, gap;
      tick = (cfg_period != 0) && (m_tmr == int'(cfg_period) - 1);
      gap  = (m_bx >= int'(cfg_gap_start)) && (m_bx <= int'(cfg_gap_end));
      case (m_ph)
        0: if (req_wr || tick) begin m_ph = 1; m_left = INH; end
        2: begin
          if (gap && derand_empty) begin
            m_ph = 3; m_left = PUL;
            if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
          end else if (m_left == 1) begin m_ph = 0; m_tmo = 1; end
          else m_left--;
        end
        default: begin
          if (m_left == 1) begin
            case (m_ph)
              1: begin m_ph = 2; m_left = int'(cfg_timeout) + 1; end
              3: begin m_ph = 4; m_left = REI; end
              4: begin m_ph = 5; m_left = REC; end
              default: m_ph = 0;
            endcase
          end else m_left--;
        end
      endcase
      m_tmr = (cfg_period == 0 || tick) ? 0 : m_tmr + 1;
      m_bx  = (m_bx + 1 >= int'(cfg_orbit_len)) ? 0 : m_bx + 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk("R1 bx_pos", bx_pos, m_bx);
      chk("R5 trig_enable", trig_enable, m_ph == 0);
      chk("R2 busy", busy, m_ph != 0);
      chk("R3 fe_reset", fe_reset, m_ph == 3);
      chk("R7 timeout_flag", timeout_flag, m_tmo);
      chk("R9 reset_count", reset_count, m_cnt);
      if (fe_reset) seen_rst = 1;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic request();
    @(negedge clk) req_wr = 1;
    @(negedge clk) req_wr = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!trig_enable);
  endtask

  initial begin
    rst_n = 0; req_wr = 0; derand_empty = 1;
    cfg_orbit_len = 64; cfg_gap_start = 50; cfg_gap_end = 60;
    cfg_period = 0; cfg_timeout = 200;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 trig_enable", trig_enable, 1);
    chk("R11 fe_reset", fe_reset, 0);
    chk("R11 busy", busy, 0);
    chk("R11 timeout_flag", timeout_flag, 0);
    chk("R11 reset_count", reset_count, 0);
    chk("R11 bx_pos", bx_pos, 0);
    rst_n = 1;

    // R2: on-demand request, accepts drop next cycle
    repeat (5) @(negedge clk);
    req_wr = 1;
    @(negedge clk) req_wr = 0;
    chk("R2 accept drop", trig_enable, 0);
    wait_idle();
    chk("R2 one reset", reset_count, 1);

    // R4: derandomizer not empty holds the pulse back
    derand_empty = 0; seen_rst = 0;
    request();
    repeat (150) @(negedge clk);
    chk("R4 no pulse while full", seen_rst, 0);
    chk("R4 count held", reset_count, 1);
    derand_empty = 1;
    wait_idle();
    chk("R4 pulse after empty", reset_count, 2);

    // R10: request during busy is dropped
    request();
    while (!fe_reset) @(negedge clk);
    repeat (20) @(negedge clk);
    request();
    wait_idle();
    repeat (300) @(negedge clk);
    chk("R10 busy request dropped", reset_count, 3);
    chk("R10 idle again", trig_enable, 1);

    // R8: last wait cycle with gap and empty: pulse wins
    cfg_gap_start = 0; cfg_gap_end = 63; cfg_timeout = 0;
    request();
    wait_idle();
    chk("R8 pulse wins", reset_count, 4);
    chk("R8 no timeout", timeout_flag, 0);

    // R7: timeout without pulse, flag sticks
    derand_empty = 0; seen_rst = 0;
    request();
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R7 flag set", timeout_flag, 1);
    chk("R7 no pulse", seen_rst, 0);
    chk("R7 count unchanged", reset_count, 4);
    derand_empty = 1; cfg_gap_start = 50; cfg_gap_end = 60; cfg_timeout = 200;

    // R6: interval requests
    cfg_period = 500;
    repeat (1700) @(negedge clk);
    chk("R6 periodic resets", reset_count, 7);
    cfg_period = 0;
    wait_idle();
    seen_rst = 0;
    repeat (1200) @(negedge clk);
    chk("R6 disabled no pulse", seen_rst, 0);

    // R9: saturation
    request();
    wait_idle();
    chk("R9 pulse issued", seen_rst, 1);
    chk("R9 saturated", reset_count, 7);
    chk("R7 flag still set", timeout_flag, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule